// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind

This block is a FIFO that moves 18-bit words from a write clock domain to a read clock domain that runs on its own, unrelated clock. Words go in on `wrClk` when `wrEn` is set and room is free. They come out on `rdClk` in the order they were written. The pointers cross between the domains as gray code through two-flop synchronisers. The full side is judged in the write domain and the empty side in the read domain.

A master reset picks one of two timing modes from `modeSel`. In standard mode the two flag outputs mean "full" and "empty", and a word reaches `rdData` one read-clock edge after an accepted read. In fall-through mode the same two outputs mean "space available" and "word valid on `rdData`". In this mode the head word is loaded into the output register without a read request. A partial reset empties the FIFO but keeps the chosen mode. A rewind request moves the read pointer back to location zero so that the stored words can be read again. A word count, taken in the write domain, and a half-full output are provided for flag logic outside the block.

Top module: `retx_fifo`

## Requirements
- R1: Every accepted word is delivered on `rdData` exactly once and in write order, in both modes. The only exception is a rewind.
- R2: While `mstRstN` is low, `modeSel` is sampled: 0 selects standard mode and 1 selects fall-through mode. After a master reset, `wrCount` is 0, `rdData` is 0 and `halfFull` is 0. `fullOrRdy` reads as not-full in standard mode and as space available in fall-through mode. `emptyOrValid` reads as empty in standard mode and as not-valid in fall-through mode.
- R3: In standard mode, `fullOrRdy`=1 means full and `emptyOrValid`=1 means empty. A read is accepted when `rdEn`=1 and `emptyOrValid`=0 at a rising `rdClk` edge. The word is on `rdData` after that edge. In standard mode a write never appears on `rdData` without a read.
- R4: In fall-through mode, `fullOrRdy`=1 means space available and `emptyOrValid`=1 means `rdData` holds the head word. The head word is loaded without `rdEn`. `rdEn`=1 while valid consumes it at that edge.
- R5: Driving `prtRstN` low clears both pointers, `wrCount` and `rdData`, and keeps the mode chosen at the last master reset, whatever `modeSel` is at that time.
- R6: A write while full is ignored. `wrCount` never exceeds DEPTH. Standard mode stores DEPTH words, and fall-through mode stores DEPTH+1 words counting the output register.
- R7: A read request while the FIFO is empty is ignored and leaves `rdData` unchanged.
- R8: `halfFull` is 1 exactly when `wrCount` is greater than DEPTH/2.
- R9: A `rewind` sampled at a rising `rdClk` edge sets the read pointer to location zero and leaves the write pointer alone. The words stored since reset are then read again from the first. Rewind is only meaningful while no more than DEPTH words have been written since the last reset.
- R10: For the two `rdClk` edges that follow a rewind edge, no word is fetched. During that time `emptyOrValid` is forced to 1 in standard mode and to 0 in fall-through mode. It is then computed again from the rewound read pointer.
- R11: Once both clocks have been idle for a few cycles, `wrCount` equals the number of words accepted minus the number taken out of the memory, including any word moved into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrEn | input | 1 | Write request |
| wrData | input | 18 | Word to store |
| fullOrRdy | output | 1 | Full (standard) or space available (fall-through) |
| halfFull | output | 1 | Count above half of capacity |
| wrCount | output | $clog2(DEPTH)+1 | Write-domain word count |
| rdClk | input | 1 | Read-domain clock |
| rdEn | input | 1 | Read request |
| rdData | output | 18 | Output register |
| emptyOrValid | output | 1 | Empty (standard) or word valid (fall-through) |
| rewind | input | 1 | Move read pointer back to location zero |
| mstRstN | input | 1 | Master reset, active low, also samples the mode |
| prtRstN | input | 1 | Partial reset, active low, keeps the mode |
| modeSel | input | 1 | Mode choice sampled during master reset |

## Verification
The two clocks run at unrelated periods. Random write and read pressure is applied in each mode. This shows whether the gray pointer crossing loses or repeats words when flags go stale between domains. Directed fills past capacity and reads from an empty FIFO separate correct refusal at the boundaries from pointer overrun. Half-fill steps of DEPTH/2 and DEPTH/2+1 pin down the half-full threshold. Rewinds are run in both modes, each followed by a drain. These show the forced flag window, that the write pointer is untouched, and that replay starts from location zero. Partial and master resets with the opposite `modeSel` show that only a master reset can change the mode.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } fifoMode_e;

  // push is a write-domain strobe; pop and clrOut are read-domain strobes
  typedef struct packed {
    logic push;
    logic pop;
    logic clrOut;
  } fifoStrb_t;
endpackage

// File: rtl/retx_fifo_sync.sv
module retx_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter  int DEPTH       = 16,
  parameter  int SYNC_STAGES = 2,
  parameter  int HOLD_CYC    = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int PW          = AW + 1,
  localparam int HW          = $clog2(HOLD_CYC + 1)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mstRstN,
  input  logic          prtRstN,
  input  logic          modeSel,
  input  logic          rewind,
  input  logic          wrEn,
  input  logic          rdEn,
  output fifoStrb_t     strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullOrRdy,
  output logic          emptyOrValid,
  output logic          halfFull,
  output logic [PW-1:0] wrCount
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  fifoMode_e     wMode;
  logic          wClr;
  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdGraySyncW, rdBinW, wCount;
  logic          wFull, pushNow;

  assign wClr = !mstRstN || !prtRstN;

  always_ff @(posedge wrClk) begin
    if (!mstRstN) wMode <= fifoMode_e'(modeSel);
  end

  retx_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) rdPtrSyncI (
    .clk (wrClk),
    .clr (wClr),
    .din (rdGray),
    .dout(rdGraySyncW)
  );

  assign rdBinW    = fromGray(rdGraySyncW);
  assign wCount    = wrBin - rdBinW;
  assign wFull     = wCount >= PW'(DEPTH);
  assign pushNow   = wrEn && !wFull;
  assign wrBinNext = wrBin + PW'(pushNow);

  always_ff @(posedge wrClk) begin
    if (wClr) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (pushNow) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  assign fullOrRdy = (wMode == MODE_FALL) ? !wFull : wFull;
  assign halfFull  = wCount > PW'(DEPTH / 2);
  assign wrCount   = wCount;
  assign wrAddr    = wrBin[AW-1:0];

  // ---------------- read domain ----------------
  fifoMode_e     rMode;
  logic          rClr;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] wrGraySyncR, wrBinR;
  logic [HW-1:0] holdCnt;
  logic          memEmpty, hold, outValid, popNow;

  assign rClr = !mstRstN || !prtRstN;

  always_ff @(posedge rdClk) begin
    if (!mstRstN) rMode <= fifoMode_e'(modeSel);
  end

  retx_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) wrPtrSyncI (
    .clk (rdClk),
    .clr (rClr),
    .din (wrGray),
    .dout(wrGraySyncR)
  );

  assign wrBinR   = fromGray(wrGraySyncR);
  assign memEmpty = rdBin == wrBinR;
  assign hold     = holdCnt != '0;

  // fall-through fetches whenever the output register is free or being drained
  always_comb begin
    if (rMode == MODE_FALL) popNow = !memEmpty && !hold && !rewind && (!outValid || rdEn);
    else                    popNow = rdEn && !memEmpty && !hold && !rewind;
  end

  assign rdBinNext = rdBin + PW'(popNow);

  always_ff @(posedge rdClk) begin
    if (rClr) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rewind) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (popNow) begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  always_ff @(posedge rdClk) begin
    if (rClr)        holdCnt <= '0;
    else if (rewind) holdCnt <= HW'(HOLD_CYC);
    else if (hold)   holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge rdClk) begin
    if (rClr || rewind || rMode != MODE_FALL) outValid <= 1'b0;
    else if (popNow)                          outValid <= 1'b1;
    else if (rdEn)                            outValid <= 1'b0;
  end

  assign emptyOrValid = (rMode == MODE_FALL) ? outValid : (memEmpty || hold);
  assign rdAddr       = rdBin[AW-1:0];

  assign strb.push   = pushNow;
  assign strb.pop    = popNow;
  assign strb.clrOut = rClr;
endmodule

// File: rtl/retx_fifo_dpath.sv
module retx_fifo_dpath
  import retx_fifo_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 18,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  fifoStrb_t        strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (strb.clrOut)   rdData <= '0;
    else if (strb.pop) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18
) (
  input  logic                     wrClk,
  input  logic                     wrEn,
  input  logic [WIDTH-1:0]         wrData,
  output logic                     fullOrRdy,
  output logic                     halfFull,
  output logic [$clog2(DEPTH):0]   wrCount,
  input  logic                     rdClk,
  input  logic                     rdEn,
  output logic [WIDTH-1:0]         rdData,
  output logic                     emptyOrValid,
  input  logic                     rewind,
  input  logic                     mstRstN,
  input  logic                     prtRstN,
  input  logic                     modeSel
);
  localparam int AW = $clog2(DEPTH);

  fifoStrb_t     strb;
  logic [AW-1:0] wrAddr, rdAddr;

  retx_fifo_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .mstRstN     (mstRstN),
    .prtRstN     (prtRstN),
    .modeSel     (modeSel),
    .rewind      (rewind),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .strb        (strb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fullOrRdy   (fullOrRdy),
    .emptyOrValid(emptyOrValid),
    .halfFull    (halfFull),
    .wrCount     (wrCount)
  );

  retx_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dpathI (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .strb  (strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18
) (
  input logic                   wrClk,
  input logic                   rdClk,
  input logic                   mstRstN,
  input logic                   prtRstN,
  input logic                   rewind,
  input logic                   pushStb,
  input logic                   popStb,
  input logic [$clog2(DEPTH):0] wrCount,
  input logic [WIDTH-1:0]       rdData
);
  // R5
  part_reset_chk: assert property (@(posedge rdClk) disable iff (!mstRstN)
    !prtRstN |=> rdData == '0);

  // R7
  out_hold_chk: assert property (@(posedge rdClk) disable iff (!mstRstN || !prtRstN)
    !popStb |=> $stable(rdData));

  // R6
  push_room_chk: assert property (@(posedge wrClk) disable iff (!mstRstN || !prtRstN)
    pushStb |-> wrCount < DEPTH);

  // R6
  count_bound_chk: assert property (@(posedge wrClk) disable iff (!mstRstN || !prtRstN)
    wrCount <= DEPTH);

  // R10
  rewind_hold_chk: assert property (@(posedge rdClk) disable iff (!mstRstN || !prtRstN)
    rewind |=> !popStb ##1 !popStb);
endmodule

bind retx_fifo retx_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chkI (
  .wrClk  (wrClk),
  .rdClk  (rdClk),
  .mstRstN(mstRstN),
  .prtRstN(prtRstN),
  .rewind (rewind),
  .pushStb(strb.push),
  .popStb (strb.pop),
  .wrCount(wrCount),
  .rdData (rdData)
);

// File: tb/tb_retx_fifo.sv
module tb_retx_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 18;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic wrClk = 1'b0, rdClk = 1'b0;
  always #5 wrClk = ~wrClk;   // 100 MHz
  always #7 rdClk = ~rdClk;   // unrelated read clock

  logic             wrEn = 0, rdEn = 0, rewind = 0;
  logic             mstRstN = 0, prtRstN = 1, modeSel = 0;
  logic [WIDTH-1:0] wrData = '0;
  logic             fullOrRdy, halfFull, emptyOrValid;
  logic [CW-1:0]    wrCount;
  logic [WIDTH-1:0] rdData;

  retx_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData), .fullOrRdy(fullOrRdy),
    .halfFull(halfFull), .wrCount(wrCount), .rdClk(rdClk), .rdEn(rdEn),
    .rdData(rdData), .emptyOrValid(emptyOrValid), .rewind(rewind),
    .mstRstN(mstRstN), .prtRstN(prtRstN), .modeSel(modeSel)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;
  bit fallMode = 0;
  logic [WIDTH-1:0] hist [4096];
  int wrIdx = 0, rdIdx = 0;

  function automatic bit expHalf(input int cnt);
    return cnt > DEPTH / 2;
  endfunction

  function automatic bit expSpaceFlag(input bit fall, input bit full);
    return fall ? !full : full;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input bit master, input bit sel);
    wrEn = 0; rdEn = 0; rewind = 0; modeSel = sel;
    @(negedge rdClk);
    if (master) mstRstN = 0; else prtRstN = 0;
    repeat (4) @(negedge rdClk);
    mstRstN = 1; prtRstN = 1;
    if (master) fallMode = sel;
    wrIdx = 0; rdIdx = 0;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  task automatic wrStep(input bit en, input logic [WIDTH-1:0] d);
    bit acc;
    @(negedge wrClk);
    acc = en && (fallMode ? fullOrRdy : !fullOrRdy);
    wrEn = en; wrData = d;
    @(posedge wrClk);
    #1 wrEn = 0;
    if (acc) begin hist[wrIdx] = d; wrIdx++; end
  endtask

  task automatic rdStep(input bit en, output bit acc);
    @(negedge rdClk);
    if (fallMode) begin
      if (emptyOrValid) chk("R1/R4 fall-through head word", rdData, hist[rdIdx]);
      acc = en && emptyOrValid;
    end else begin
      acc = en && !emptyOrValid;
    end
    rdEn = en;
    @(posedge rdClk);
    #3 rdEn = 0;
    if (acc && !fallMode) chk("R1/R3 standard read word", rdData, hist[rdIdx]);
    if (acc) rdIdx++;
  endtask

  task automatic drain(output int got);
    bit acc;
    got = 0;
    idle(10);
    for (int g = 0; g < 4 * DEPTH; g++) begin
      rdStep(1, acc);
      if (!acc) break;
      got++;
    end
  endtask

  task automatic randWrites(input int n, input int pct);
    for (int i = 0; i < n; i++) wrStep($urandom_range(99) < pct, WIDTH'($urandom));
  endtask

  task automatic randReads(input int n, input int pct);
    bit acc;
    for (int i = 0; i < n; i++) rdStep($urandom_range(99) < pct, acc);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run hung (R1 progress)");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int got;
    bit acc;
    logic [WIDTH-1:0] keep;
    void'($urandom(32'h5eed_0123));

    // ---- R2: master reset into standard mode ----
    doReset(1, 0);
    chk("R2 empty after reset", emptyOrValid, 1);
    chk("R2 not full after reset", fullOrRdy, expSpaceFlag(0, 0));
    chk("R2 count after reset", wrCount, 0);
    chk("R2 rdData after reset", rdData, 0);
    chk("R2/R8 halfFull after reset", halfFull, 0);

    // ---- R7: read from empty is ignored ----
    keep = rdData;
    for (int i = 0; i < 3; i++) rdStep(1, acc);
    chk("R7 empty read leaves rdData", rdData, keep);
    chk("R7 empty read not accepted", rdIdx, 0);

    // ---- R6/R3: overfill in standard mode ----
    for (int i = 0; i < DEPTH + 3; i++) wrStep(1, WIDTH'(100 + i));
    idle(6);
    chk("R6 accepted words at full", wrIdx, DEPTH);
    chk("R6 count capped", wrCount, DEPTH);
    chk("R3 full flag", fullOrRdy, 1);
    chk("R3 not empty", emptyOrValid, 0);
    chk("R8 halfFull when full", halfFull, expHalf(DEPTH));
    drain(got);
    chk("R6 words read back", got, DEPTH);
    idle(6);
    chk("R11 count after drain", wrCount, 0);

    // ---- R8: half-full threshold ----
    for (int i = 0; i < DEPTH / 2; i++) wrStep(1, WIDTH'(i + 7));
    idle(6);
    chk("R11 count at half", wrCount, DEPTH / 2);
    chk("R8 halfFull at exactly half", halfFull, expHalf(DEPTH / 2));
    wrStep(1, 18'h3abcd);
    idle(6);
    chk("R8 halfFull above half", halfFull, expHalf(DEPTH / 2 + 1));
    drain(got);
    chk("R1 half test drain", got, DEPTH / 2 + 1);

    // ---- R1: random traffic, standard mode ----
    fork
      randWrites(400, 60);
      randReads(300, 50);
    join
    drain(got);
    chk("R1 standard random all delivered", rdIdx, wrIdx);
    idle(6);
    chk("R11 count after random", wrCount, 0);

    // ---- R5/R9/R10: partial reset, rewind in standard mode ----
    doReset(0, 1);
    chk("R5 rdData cleared", rdData, 0);
    chk("R5 count cleared", wrCount, 0);
    chk("R5 still standard (empty)", emptyOrValid, 1);
    for (int i = 0; i < 5; i++) wrStep(1, WIDTH'(i + 'h200));
    idle(6);
    chk("R5 no fall-through after partial reset", rdData, 0);
    for (int i = 0; i < 3; i++) rdStep(1, acc);
    @(negedge rdClk) rewind = 1;
    @(posedge rdClk) #3 rewind = 0;
    chk("R10 empty forced after rewind edge", emptyOrValid, 1);
    @(posedge rdClk) #3;
    chk("R10 empty forced second cycle", emptyOrValid, 1);
    @(posedge rdClk) #3;
    chk("R10 empty recomputed", emptyOrValid, 0);
    rdIdx = 0;
    idle(6);
    chk("R9 write pointer kept", wrCount, 5);
    drain(got);
    chk("R9 replay length", got, 5);

    // ---- R2/R4: master reset into fall-through ----
    doReset(1, 1);
    chk("R2 fall-through space after reset", fullOrRdy, expSpaceFlag(1, 0));
    chk("R2 fall-through not valid after reset", emptyOrValid, 0);
    wrStep(1, 18'h15a5a);
    idle(6);
    chk("R4 first word valid without read", emptyOrValid, 1);
    chk("R4 first word on rdData", rdData, 18'h15a5a);
    drain(got);
    chk("R4 single word consumed", got, 1);

    fork
      randWrites(400, 55);
      randReads(300, 60);
    join
    drain(got);
    chk("R1 fall-through random all delivered", rdIdx, wrIdx);

    for (int i = 0; i < DEPTH + 3; i++) wrStep(1, WIDTH'(i + 'h300));
    idle(8);
    chk("R6 fall-through count capped", wrCount, DEPTH);
    chk("R4 no space when full", fullOrRdy, 0);
    drain(got);
    chk("R6 fall-through capacity", got, DEPTH + 1);

    // ---- R5/R9/R10: partial reset keeps fall-through, rewind ----
    doReset(0, 0);
    chk("R5 fall-through rdData cleared", rdData, 0);
    for (int i = 0; i < 4; i++) wrStep(1, WIDTH'(i + 'h400));
    idle(6);
    chk("R5 mode kept: valid without read", emptyOrValid, 1);
    for (int i = 0; i < 2; i++) rdStep(1, acc);
    @(negedge rdClk) rewind = 1;
    @(posedge rdClk) #3 rewind = 0;
    chk("R10 valid dropped at rewind", emptyOrValid, 0);
    @(posedge rdClk) #3;
    chk("R10 valid held low", emptyOrValid, 0);
    @(posedge rdClk) #3;
    chk("R10 no fetch during hold", emptyOrValid, 0);
    @(posedge rdClk) #3;
    chk("R10 valid after hold", emptyOrValid, 1);
    chk("R9 replay starts at first word", rdData, 18'h400);
    rdIdx = 0;
    drain(got);
    chk("R9 fall-through replay length", got, 4);

    // ---- R2: master reset back to standard ----
    doReset(1, 0);
    wrStep(1, 18'h2f0f0);
    idle(6);
    chk("R2 standard: not empty", emptyOrValid, 0);
    chk("R3 no fall-through in standard", rdData, 0);
    rdStep(1, acc);
    chk("R3 read accepted", acc, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule